// File: doc/BRIEF.md
# Rotating Bit-Serial Weight Bank

This block keeps every coefficient of a block-adaptive FIR filter in shift registers. The registers form a matrix with `NROW` rows and `NCOL` columns, and column `p` holds the `p`-th short weight vector. The filter reads its tables by weight bit-slices. Once per iteration the block does two jobs on the same registers.

First, during the update phase, it adds an externally computed increment to each weight. The add is bit-serial, least significant bit first, with one full adder and one carry flip-flop per weight. Second, during the later shift phase, it presents one `NROW`-bit slice per column on every clock, least significant bit first, for use as table addresses. During that same pass, each column's register takes in the bits of the column to its right. When the pass ends, the weight columns have therefore moved one place to the left, circularly. This keeps each table column paired with the correct weight vector, and no table contents have to move.

An iteration starts when `iter_start` is seen while the block is idle. Cycle k of an iteration is the k-th clock period after that sampling edge, counting from zero. The update runs in cycles 0 to `WW-1`. The shift runs in cycles `SHF_START` to `SHF_START+WW-1`. The block is idle again from cycle `SHF_START+WW`. The update fits inside the table-refresh period of `TBL_CYC` cycles, so it does not lengthen the iteration.

Top module: `wgt_rot_bank`

## Requirements
- R1: A synchronous reset clears every weight to zero and leaves the block idle, with `upd_act` and `slice_vld` low.
- R2: A high `iter_start` while the block is idle starts an iteration. `upd_act` is high in exactly cycles 0 to `WW-1` of it. While idle with `iter_start` low, the block stays idle.
- R3: After an iteration, each weight equals its old value plus its increment, modulo 2^`WW`, in two's complement. Bit j of the increment for column p, row n is taken from `inc_bits[p*NROW+n]` in update cycle j.
- R4: The carry of every weight's adder is forced to zero in update cycle 0, so a carry left over from an earlier iteration never reaches a later sum.
- R5: `inc_bits` has no effect outside the update cycles.
- R6: `slice_vld` is high in exactly cycles `SHF_START` to `SHF_START+WW-1` of an iteration and is never high together with `upd_act`.
- R7: In shift cycle j (cycle `SHF_START+j`), `slice[p*NROW+n]` is bit j of the updated weight in column p, row n.
- R8: After an iteration, column p holds the updated weights that column (p+1) mod `NCOL` held, row for row.
- R9: `iter_start` is ignored while an iteration is in progress, including its last shift cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| iter_start | input | 1 | Starts an iteration when the block is idle |
| inc_bits | input | NCOL*NROW | Serial increment bits, one per weight, index p*NROW+n |
| upd_act | output | 1 | High during the update cycles |
| slice | output | NCOL*NROW | Weight bit-slices, index p*NROW+n |
| slice_vld | output | 1 | High during the shift cycles |

## Verification
The carry clear and the first bit of a new sum fall in the same clock, update cycle 0. The bench provokes this by running an iteration whose adds all overflow, leaving every carry flip-flop at one, and following it with an iteration of zero increments. It then judges the outcome by reading the weights back through the slices, where any leaked carry shows up as an off-by-one. A second collision is a start request during the last shift cycle, the cycle in which the block returns to idle. The bench judges this by requiring `upd_act` and `slice_vld` to be low in the next cycle.

// File: rtl/wgt_rot_pkg.sv
package wgt_rot_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_UPD  = 2'd1,
      PH_GAP  = 2'd2,
      PH_SHF  = 2'd3
   } phase_e;

   // column whose bits feed column p during the rotating shift
   function automatic int rot_src(input int p, input int ncol);
      return (p + 1) % ncol;
   endfunction

endpackage

// File: rtl/wgt_rot_seq.sv
module wgt_rot_seq
   import wgt_rot_pkg::*;
#(
   parameter int WW        = 8,
   parameter int SHF_START = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   output logic upd,
   output logic clr_c,
   output logic shf,
   output logic busy
);

   localparam int LAST = SHF_START + WW - 1;
   localparam int CW   = $clog2(LAST + 1);

   phase_e          ph_q;
   logic [CW-1:0]   cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         ph_q  <= PH_IDLE;
         cnt_q <= '0;
      end else begin
         unique case (ph_q)
            PH_IDLE: begin
               if (start) begin
                  ph_q  <= PH_UPD;
                  cnt_q <= '0;
               end
            end
            PH_UPD: begin
               cnt_q <= cnt_q + CW'(1);
               if (cnt_q == CW'(WW - 1))
                  ph_q <= (SHF_START == WW) ? PH_SHF : PH_GAP;
            end
            PH_GAP: begin
               cnt_q <= cnt_q + CW'(1);
               if (cnt_q == CW'(SHF_START - 1))
                  ph_q <= PH_SHF;
            end
            PH_SHF: begin
               if (cnt_q == CW'(LAST)) begin
                  ph_q  <= PH_IDLE;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + CW'(1);
               end
            end
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   assign upd   = (ph_q == PH_UPD);
   assign clr_c = (ph_q == PH_UPD) && (cnt_q == '0);
   assign shf   = (ph_q == PH_SHF);
   assign busy  = (ph_q != PH_IDLE);

endmodule

// File: rtl/wgt_rot_cell.sv
module wgt_rot_cell #(
   parameter int WW = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic upd,
   input  logic clr_c,
   input  logic shf,
   input  logic inc_bit,
   input  logic rot_in,
   output logic lsb
);

   logic [WW-1:0] w_q;
   logic          c_q;
   logic          cin;
   logic          sum;
   logic          cout;

   // carry of the previous iteration is dropped in the first update cycle
   assign cin  = clr_c ? 1'b0 : c_q;
   assign sum  = w_q[0] ^ inc_bit ^ cin;
   assign cout = (w_q[0] & inc_bit) | (w_q[0] & cin) | (inc_bit & cin);

   always_ff @(posedge clk) begin
      if (rst) begin
         w_q <= '0;
         c_q <= 1'b0;
      end else if (upd) begin
         w_q <= {sum, w_q[WW-1:1]};
         c_q <= cout;
      end else if (shf) begin
         w_q <= {rot_in, w_q[WW-1:1]};
      end
   end

   assign lsb = w_q[0];

endmodule

// File: rtl/wgt_rot_col.sv
module wgt_rot_col #(
   parameter int NROW = 4,
   parameter int WW   = 8
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            upd,
   input  logic            clr_c,
   input  logic            shf,
   input  logic [NROW-1:0] inc_bits,
   input  logic [NROW-1:0] rot_in,
   output logic [NROW-1:0] lsbs
);

   for (genvar n = 0; n < NROW; n++) begin : g_row
      wgt_rot_cell #(.WW(WW)) cell_i (
         .clk     (clk),
         .rst     (rst),
         .upd     (upd),
         .clr_c   (clr_c),
         .shf     (shf),
         .inc_bit (inc_bits[n]),
         .rot_in  (rot_in[n]),
         .lsb     (lsbs[n])
      );
   end

endmodule

// File: rtl/wgt_rot_bank.sv
module wgt_rot_bank
   import wgt_rot_pkg::*;
#(
   parameter int NROW      = 4,
   parameter int NCOL      = 4,
   parameter int WW        = 8,
   parameter int TBL_CYC   = 16,
   parameter int SHF_START = 16
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 iter_start,
   input  logic [NCOL*NROW-1:0] inc_bits,
   output logic                 upd_act,
   output logic [NCOL*NROW-1:0] slice,
   output logic                 slice_vld
);

   localparam int NW = NCOL * NROW;

   if (NROW < 1 || NCOL < 1) begin : g_bad_dim
      $error("wgt_rot_bank: NROW and NCOL must be at least 1");
   end
   if (WW < 2) begin : g_bad_ww
      $error("wgt_rot_bank: WW must be at least 2");
   end
   if (WW > TBL_CYC) begin : g_bad_fit
      $error("wgt_rot_bank: WW must not exceed TBL_CYC");
   end
   if (SHF_START < WW) begin : g_bad_start
      $error("wgt_rot_bank: SHF_START must not precede the end of the update");
   end

   logic upd;
   logic clr_c;
   logic shf;
   logic busy;
   logic [NW-1:0] lsb_all;

   wgt_rot_seq #(.WW(WW), .SHF_START(SHF_START)) seq_i (
      .clk   (clk),
      .rst   (rst),
      .start (iter_start),
      .upd   (upd),
      .clr_c (clr_c),
      .shf   (shf),
      .busy  (busy)
   );

   for (genvar p = 0; p < NCOL; p++) begin : g_col
      logic [NROW-1:0] rot_in;
      if (NCOL == 1) begin : g_self
         assign rot_in = lsb_all[NROW-1:0];
      end else begin : g_next
         assign rot_in = lsb_all[rot_src(p, NCOL)*NROW +: NROW];
      end
      wgt_rot_col #(.NROW(NROW), .WW(WW)) col_i (
         .clk      (clk),
         .rst      (rst),
         .upd      (upd),
         .clr_c    (clr_c),
         .shf      (shf),
         .inc_bits (inc_bits[p*NROW +: NROW]),
         .rot_in   (rot_in),
         .lsbs     (lsb_all[p*NROW +: NROW])
      );
   end

   assign upd_act   = upd;
   assign slice     = lsb_all;
   assign slice_vld = shf;

endmodule

// File: rtl/wgt_rot_chk.sv
module wgt_rot_chk #(
   parameter int WW = 8
) (
   input logic clk,
   input logic rst,
   input logic iter_start,
   input logic upd_act,
   input logic slice_vld,
   input logic clr_c,
   input logic busy
);

   localparam int RW = $clog2(WW + 1) + 1;

   logic [RW-1:0] run_q;

   always_ff @(posedge clk) begin
      if (rst)
         run_q <= '0;
      else if (slice_vld)
         run_q <= run_q + RW'(1);
      else
         run_q <= '0;
   end

   AST_RST_IDLE: assert property (@(posedge clk)
      rst |=> (!upd_act && !slice_vld && !busy)); // R1

   AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst)
      (!busy && iter_start) |=> (upd_act && clr_c)); // R2

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!busy && !iter_start) |=> !busy); // R2

   AST_CLR_FIRST_ONLY: assert property (@(posedge clk) disable iff (rst)
      (upd_act && $past(upd_act)) |-> !clr_c); // R4

   AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
      !(upd_act && slice_vld)); // R6

   AST_SHF_LEN: assert property (@(posedge clk) disable iff (rst)
      $fell(slice_vld) |-> (run_q == RW'(WW))); // R6

   AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
      (busy && iter_start) |=> !clr_c); // R9

endmodule

bind wgt_rot_bank wgt_rot_chk #(.WW(WW)) chk_i (
   .clk        (clk),
   .rst        (rst),
   .iter_start (iter_start),
   .upd_act    (upd_act),
   .slice_vld  (slice_vld),
   .clr_c      (clr_c),
   .busy       (busy)
);

// File: tb/wgt_rot_bank_tb_top.sv
`timescale 1ns/1ps
module wgt_rot_bank_tb_top;

   localparam int NR  = 2;
   localparam int NC  = 3;
   localparam int WW  = 6;
   localparam int SS  = 8;
   localparam int NW  = NR * NC;
   localparam int MSK = (1 << WW) - 1;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          iter_start = 1'b0;
   logic [NW-1:0] inc_bits = '0;
   logic          upd_act;
   logic [NW-1:0] slice;
   logic          slice_vld;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   int w_m  [NC][NR];
   int inc_m[NC][NR];

   always #10 clk = ~clk;

   wgt_rot_bank #(
      .NROW(NR), .NCOL(NC), .WW(WW), .TBL_CYC(8), .SHF_START(SS)
   ) dut_i (
      .clk        (clk),
      .rst        (rst),
      .iter_start (iter_start),
      .inc_bits   (inc_bits),
      .upd_act    (upd_act),
      .slice      (slice),
      .slice_vld  (slice_vld)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic set_inc(input int base, input int sp, input int sn);
      for (int p = 0; p < NC; p++)
         for (int n = 0; n < NR; n++)
            inc_m[p][n] = (base + p * sp + n * sn) & MSK;
   endtask

   // one full iteration; noise drives start requests while busy (R9)
   task automatic run_iter(input string req, input bit noise);
      int got[NC][NR];
      int phase_err;
      int nw[NC][NR];
      phase_err = 0;
      for (int p = 0; p < NC; p++)
         for (int n = 0; n < NR; n++) got[p][n] = 0;
      @(negedge clk);
      iter_start = 1'b1;
      inc_bits   = '1;                        // R5: not an update cycle yet
      @(posedge clk);
      for (int j = 0; j < WW; j++) begin
         @(negedge clk);
         iter_start = 1'b0;
         if (!upd_act || slice_vld) phase_err++;
         for (int p = 0; p < NC; p++)
            for (int n = 0; n < NR; n++)
               inc_bits[p*NR+n] = inc_m[p][n][j];
         @(posedge clk);
      end
      for (int p = 0; p < NC; p++)
         for (int n = 0; n < NR; n++)
            w_m[p][n] = (w_m[p][n] + inc_m[p][n]) & MSK;
      for (int c = WW; c < SS; c++) begin
         @(negedge clk);
         iter_start = noise;
         inc_bits   = NW'(c * 37 + 5);        // R5 garbage
         if (upd_act || slice_vld) phase_err++;
         @(posedge clk);
      end
      for (int j = 0; j < WW; j++) begin
         @(negedge clk);
         iter_start = noise;
         inc_bits   = ~NW'(j * 11 + 3);       // R5 garbage
         if (upd_act || !slice_vld) phase_err++;
         for (int p = 0; p < NC; p++)
            for (int n = 0; n < NR; n++)
               got[p][n] |= int'(slice[p*NR+n]) << j;
         @(posedge clk);
      end
      @(negedge clk);
      iter_start = 1'b0;
      inc_bits   = '0;
      chk(phase_err == 0, "R2 R6", "phase timing errors", phase_err, 0);
      chk(!upd_act && !slice_vld, "R9", "active after iteration end",
          int'({upd_act, slice_vld}), 0);
      for (int p = 0; p < NC; p++)
         for (int n = 0; n < NR; n++)
            chk(got[p][n] == w_m[p][n], req, $sformatf("weight[%0d][%0d]", p, n),
                got[p][n], w_m[p][n]);
      for (int p = 0; p < NC; p++)
         for (int n = 0; n < NR; n++)
            nw[p][n] = w_m[(p + 1) % NC][n];  // R8 model
      w_m = nw;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      iter_start = 1'b1;
      inc_bits = '1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      iter_start = 1'b0;
      inc_bits = '0;
      chk(!upd_act && !slice_vld, "R1", "outputs after reset",
          int'({upd_act, slice_vld}), 0);
      for (int p = 0; p < NC; p++)
         for (int n = 0; n < NR; n++) w_m[p][n] = 0;
   endtask

   initial begin
      for (int p = 0; p < NC; p++)
         for (int n = 0; n < NR; n++) w_m[p][n] = 0;
      do_reset();
      repeat (3) begin
         @(negedge clk);
         chk(!upd_act && !slice_vld, "R2", "idle without start",
             int'({upd_act, slice_vld}), 0);
      end
      set_inc(0, 0, 0);
      run_iter("R1", 1'b0);
      // R4: overflow leaves every carry at one, then zero increments
      set_inc(MSK, 0, 0);
      run_iter("R3", 1'b0);
      set_inc(1, 0, 0);
      run_iter("R4", 1'b0);
      set_inc(0, 0, 0);
      run_iter("R4", 1'b1);
      // R8: distinct weights, then a pure rotation pass
      set_inc(1, 10, 3);
      run_iter("R7", 1'b0);
      set_inc(0, 0, 0);
      run_iter("R8", 1'b0);
      run_iter("R8", 1'b1);
      // sweep of increment patterns, with and without busy start requests
      for (int it = 0; it < 32; it++) begin
         set_inc(it * 13 + 5, 29, 7 + it);
         run_iter("R3 R5 R7", it[0]);
      end
      do_reset();
      set_inc(0, 0, 0);
      run_iter("R1", 1'b0);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule